// File: doc/BRIEF.md
# One-Time-Programmable Area Program Guard

This block owns a 1 KB one-time-programmable byte area and decides, for each program request, whether the request may modify the addressed byte. The area is split into 32 regions of 32 bytes. Region 0 holds a factory random number, a 32-bit lock vector and a reserved span. The other regions hold user bytes. Each region has one lock bit in the lock vector. A region whose lock bit is 0 cannot be programmed. Because programming can only clear bits, a lock cannot be undone.

A requester presents one request per cycle: a byte address, a data byte and a flag that selects program or read. One cycle later the block returns a response with the resulting byte and a status code. A program that is allowed stores the bitwise AND of the old byte and the new data. Reset loads the delivery state of the area. The random number comes from a parameter and every other byte is FFh.

Top module: `otp_lock_guard`

## Requirements
- R1: After reset `rsp_valid` is 0. Bytes 000h–00Fh hold the random seed, least significant seed byte at 000h. Every other byte, including the lock bytes, reads FFh.
- R2: Each request with `req_valid`=1 gives exactly one response: `rsp_valid` is 1 in the cycle after the request and 0 after a cycle with no request.
- R3: A read (`req_write`=0) of any address returns the stored byte on `rsp_rdata` with status 00 (accepted).
- R4: An accepted program stores old AND data, so bits only go from 1 to 0. The response returns the new byte with status 00.
- R5: A program to 000h–00Fh (random number) or 014h–01Fh (reserved) is rejected with status 10 (protected). The byte is unchanged and is returned as `rsp_rdata`.
- R6: Region n covers n×20h to n×20h+1Fh. Its lock bit is bit n mod 8 of byte 010h + n/8. A program to a region whose lock bit is 0 is rejected with status 01 (locked), and the byte is unchanged and returned.
- R7: Lock bytes 010h–013h are programmable while region 0 is unlocked. A new lock value governs the very next request, including a back-to-back one.
- R8: Once bit 0 of byte 010h is 0, programs to the lock bytes are rejected with status 01, so the lock vector is frozen.
- R9: The protected check has priority over the lock check. A program to 000h–00Fh or 014h–01Fh reports status 10 even while region 0 is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loads the delivery state |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = program, 0 = read |
| req_addr | input | 10 | Byte address |
| req_wdata | input | 8 | Program data |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_rdata | output | 8 | Byte value after the request |
| rsp_status | output | 2 | 00 accepted, 01 locked, 10 protected |

## Verification
The hardest case is a program that is rejected only because of a lock bit written by the request just before it. It exercises the lock lookup against freshly stored state rather than the reset value. The stimulus clears a lock bit and, in the very next cycle, programs a byte in that region. It then freezes region 0 and probes both a lock byte and a protected byte. This separates the locked rejection from the protected rejection and checks the order between the two.

// File: rtl/otp_guard_pkg.sv
package otp_guard_pkg;
   typedef enum logic [1:0] {
      ST_OK     = 2'b00,
      ST_LOCKED = 2'b01,
      ST_PROT   = 2'b10
   } otp_status_e;
endpackage

// File: rtl/otp_addr_class.sv
module otp_addr_class #(
   parameter int ADDR_W      = 10,
   parameter int REG_LOG2    = 5,
   parameter int RAND_BYTES  = 16,
   parameter int LOCK_BASE   = 16,
   parameter int LOCK_BYTES  = 4,
   localparam int REGION_W   = ADDR_W - REG_LOG2,
   localparam int REG_BYTES  = 1 << REG_LOG2
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [REGION_W-1:0] region,
   output logic                is_rand,
   output logic                is_rsvd,
   output logic                is_lock
);
   int unsigned a;

   always_comb begin
      a       = int'(addr);
      region  = addr[ADDR_W-1 -: REGION_W];
      is_rand = a < RAND_BYTES;
      is_lock = (a >= LOCK_BASE) && (a < LOCK_BASE + LOCK_BYTES);
      is_rsvd = (a >= LOCK_BASE + LOCK_BYTES) && (a < REG_BYTES);
   end
endmodule

// File: rtl/otp_byte_store.sv
module otp_byte_store #(
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 8,
   parameter int RAND_BYTES = 16,
   parameter int LOCK_BASE  = 16,
   parameter int LOCK_BYTES = 4,
   parameter logic [RAND_BYTES*DATA_W-1:0] SEED = '0,
   localparam int DEPTH     = 1 << ADDR_W,
   localparam int LOCK_BITS = LOCK_BYTES * DATA_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [DATA_W-1:0]    rd_data,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   output logic [LOCK_BITS-1:0] lock_vec
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (i < RAND_BYTES) mem[i] <= SEED[i*DATA_W +: DATA_W];
            else                mem[i] <= '1;
         end
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem[rd_addr];

   for (genvar b = 0; b < LOCK_BYTES; b++) begin : g_lock
      assign lock_vec[b*DATA_W +: DATA_W] = mem[LOCK_BASE + b];
   end
endmodule

// File: rtl/otp_lock_guard.sv
module otp_lock_guard
   import otp_guard_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 8,
   parameter int REG_LOG2   = 5,
   parameter int RAND_BYTES = 16,
   parameter int LOCK_BASE  = 16,
   parameter logic [RAND_BYTES*DATA_W-1:0] SEED =
      128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [1:0]        rsp_status
);
   localparam int REGION_W    = ADDR_W - REG_LOG2;
   localparam int NUM_REGIONS = 1 << REGION_W;
   localparam int LOCK_BYTES  = NUM_REGIONS / DATA_W;
   localparam int REG_BYTES   = 1 << REG_LOG2;

   if (NUM_REGIONS % DATA_W != 0) begin : g_bad_lock_split
      $error("region count must be a multiple of the data width");
   end
   if (LOCK_BASE + LOCK_BYTES > REG_BYTES) begin : g_bad_lock_place
      $error("lock bytes must fit inside region 0");
   end
   if (RAND_BYTES > LOCK_BASE) begin : g_bad_rand
      $error("random bytes overlap the lock bytes");
   end

   logic [REGION_W-1:0]    region;
   logic                   is_rand, is_rsvd, is_lock;
   logic [DATA_W-1:0]      old_byte, new_byte;
   logic [NUM_REGIONS-1:0] lock_vec;
   logic                   do_prog;
   otp_status_e            status_d;

   otp_addr_class #(
      .ADDR_W(ADDR_W), .REG_LOG2(REG_LOG2), .RAND_BYTES(RAND_BYTES),
      .LOCK_BASE(LOCK_BASE), .LOCK_BYTES(LOCK_BYTES)
   ) i_class (
      .addr(req_addr), .region(region),
      .is_rand(is_rand), .is_rsvd(is_rsvd), .is_lock(is_lock)
   );

   otp_byte_store #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAND_BYTES(RAND_BYTES),
      .LOCK_BASE(LOCK_BASE), .LOCK_BYTES(LOCK_BYTES), .SEED(SEED)
   ) i_store (
      .clk(clk), .rst_n(rst_n),
      .rd_addr(req_addr), .rd_data(old_byte),
      .wr_en(do_prog), .wr_addr(req_addr), .wr_data(new_byte),
      .lock_vec(lock_vec)
   );

   always_comb begin
      status_d = ST_OK;
      if (req_write) begin
         if (is_rand || is_rsvd)     status_d = ST_PROT;
         else if (!lock_vec[region]) status_d = ST_LOCKED;
      end
      do_prog  = req_valid && req_write && (status_d == ST_OK);
      new_byte = do_prog ? (old_byte & req_wdata) : old_byte;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
         rsp_status <= ST_OK;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_rdata  <= new_byte;
            rsp_status <= status_d;
         end
      end
   end

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == $past(req_valid)) else $error("rsp timing"); // R2
   AST_READ_OK: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write |=> rsp_status == ST_OK && rsp_rdata == $past(old_byte))
      else $error("read"); // R3
   AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write |=> (rsp_rdata & ~$past(old_byte)) == '0)
      else $error("program set a bit"); // R4
   AST_PROT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && (is_rand || is_rsvd) |=>
      rsp_status == ST_PROT && rsp_rdata == $past(old_byte))
      else $error("protected byte"); // R5
   AST_LOCKED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_status == ST_LOCKED |-> rsp_rdata == $past(old_byte))
      else $error("locked byte changed"); // R6
   AST_LOCK_NO_REVIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_vec & ~$past(lock_vec)) == '0) else $error("lock revived"); // R8
endmodule

// File: tb/test_otp_lock_guard.sv
module test_otp_lock_guard;
   localparam logic [127:0] SEED = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;

   logic       clk = 0;
   logic       rst_n = 0;
   logic       req_valid = 0, req_write = 0;
   logic [9:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       rsp_valid;
   logic [7:0] rsp_rdata;
   logic [1:0] rsp_status;
   int checks = 0, errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   otp_lock_guard i_otp_lock_guard (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .rsp_status(rsp_status)
   );

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic xfer(bit wr, int addr, int data, int exp_d, int exp_s, string tag);
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = 10'(addr); req_wdata = 8'(data);
      @(negedge clk);
      req_valid = 0;
      check({tag, " valid"}, rsp_valid, 1);
      check({tag, " data"}, rsp_rdata, exp_d);
      check({tag, " status"}, rsp_status, exp_s);
   endtask

   task automatic t_reset();
      check("R1 rsp_valid low", rsp_valid, 0);
      xfer(0, 'h000, 0, SEED[7:0], 0, "R1 rand lsb");
      xfer(0, 'h00F, 0, SEED[127:120], 0, "R1 rand msb");
      xfer(0, 'h010, 0, 'hFF, 0, "R1 lock byte");
      xfer(0, 'h3FF, 0, 'hFF, 0, "R1 top byte");
      @(negedge clk);
      check("R2 idle no rsp", rsp_valid, 0);
   endtask

   task automatic t_program();
      xfer(1, 'h045, 'hA5, 'hA5, 0, "R4 first prog");
      xfer(1, 'h045, 'h3C, 'h24, 0, "R4 and prog");
      xfer(1, 'h045, 'hFF, 'h24, 0, "R4 no set");
      xfer(0, 'h045, 0, 'h24, 0, "R3 readback");
   endtask

   task automatic t_protected();
      xfer(1, 'h005, 'h00, SEED[47:40], 2, "R5 rand prog");
      xfer(0, 'h005, 0, SEED[47:40], 0, "R5 rand kept");
      xfer(1, 'h014, 'h00, 'hFF, 2, "R5 rsvd prog");
      xfer(0, 'h01F, 0, 'hFF, 0, "R5 rsvd read");
   endtask

   task automatic t_lock();
      xfer(1, 'h010, 'hFD, 'hFD, 0, "R7 lock region1");
      xfer(1, 'h030, 'h00, 'hFF, 1, "R7 back-to-back locked");
      xfer(1, 'h040, 'h0F, 'h0F, 0, "R6 region2 open");
      xfer(1, 'h013, 'h7F, 'h7F, 0, "R6 lock region31");
      xfer(1, 'h3E0, 'h00, 'hFF, 1, "R6 region31 low");
      xfer(1, 'h3FF, 'h00, 'hFF, 1, "R6 region31 high");
      xfer(1, 'h011, 'hFD, 'hFD, 0, "R6 lock region9");
      xfer(1, 'h120, 'h00, 'hFF, 1, "R6 region9 locked");
      xfer(1, 'h100, 'h00, 'h00, 0, "R6 region8 open");
      xfer(1, 'h010, 'hFF, 'hFD, 0, "R4 lock not revived");
      xfer(1, 'h030, 'h00, 'hFF, 1, "R6 still locked");
   endtask

   task automatic t_region0();
      xfer(1, 'h010, 'hFE, 'hFC, 0, "R8 lock region0");
      xfer(1, 'h011, 'h00, 'hFD, 1, "R8 lock byte frozen");
      xfer(0, 'h011, 0, 'hFD, 0, "R8 lock byte kept");
      xfer(1, 'h000, 'h00, SEED[7:0], 2, "R9 prot over lock");
      xfer(1, 'h018, 'h00, 'hFF, 2, "R9 rsvd over lock");
      xfer(1, 'h060, 'h55, 'h55, 0, "R6 region3 open");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_program();
      t_protected();
      t_lock();
      t_region0();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule